// File: doc/BRIEF.md
# Diversity Gain Sign Sequencer

When transmit diversity is on, this block tells the pilot gain stage whether to negate its gain. It does so from a chip position counter that runs over a fixed-length frame. The sign follows an asymmetric pattern:

- positive for a short lead-in run at the start of the frame;
- then opposite-sign runs of twice that length, alternating;
- a closing run of the lead-in length, always negative, ending the frame.

The pattern repeats without change in every frame.

Frame alignment comes from a sync pulse. The pulse loads a delay counter that counts samples (clock cycles). When that counter has run out, the chip counter restarts at position zero. A chip enable advances the chip position. The diversity enable gates the output.

Top module: `div_sign_seq`

## Requirements
- R1: During and directly after reset the chip position is zero and `negate_o` is 0.
- R2: For chip positions 0 to 255 of a frame, `negate_o` is 0 (positive gain).
- R3: From chip position 256 on, the sign alternates in runs of 512 chips, with the first run negative: positions 256..767 give 1, positions 768..1279 give 0, and so on.
- R4: The last 256 chips of the frame, positions 38144..38399, give `negate_o` = 1.
- R5: The frame is 38400 chips long. After position 38399 the position wraps to 0 and the pattern repeats identically.
- R6: The chip position advances by one only on a clock edge where `chip_en_i` is 1. Otherwise it holds.
- R7: A sync pulse sampled at an edge with `delay_i` = D makes the chip position 0 at the edge D+1 clock cycles later. Chip enables in between still advance the old count.
- R8: A sync pulse that arrives while an earlier delay is still pending reloads the delay from the new `delay_i`. Only the latest pulse takes effect.
- R9: While `div_en_i` is 0, `negate_o` is 0 whatever the chip position.
- R10: With `delay_i` = 0, the restart takes effect at the edge after the sync edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Frame sync pulse |
| delay_i | input | 16 | Restart delay in samples, captured with the sync pulse |
| div_en_i | input | 1 | Transmit diversity enable |
| chip_en_i | input | 1 | Advances the chip position by one |
| negate_o | output | 1 | 1 = negate the pilot gain |

## Verification
Two conditions are the hardest to reach from the ports.

- The closing negative run and the frame wrap only appear after 38400 chip enables. The stimulus therefore runs the chip enable every cycle for more than two full frames, starting from a delayed sync, so that both the end of the frame and its repeat are covered.
- A restart that is superseded by a second sync only shows up if the second pulse lands inside the first delay window. A long first delay is loaded and then overridden partway through by a short one.

After those two cases, the stimulus thins the chip enable to half rate, drops the diversity enable, and covers a zero-delay restart.

// File: rtl/div_sign_seq.sv
module div_sign_seq #(
  parameter int FRAME_CHIPS = 38400,
  parameter int LEAD_CHIPS  = 256,
  parameter int CW          = 16,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [DW-1:0] delay_i,
  input  logic          div_en_i,
  input  logic          chip_en_i,
  output logic          negate_o
);
  localparam int          RUN_BIT = $clog2(LEAD_CHIPS) + 1;
  localparam logic [CW-1:0] LAST  = CW'(FRAME_CHIPS - 1);
  localparam logic [CW:0]   LEAD  = (CW+1)'(LEAD_CHIPS);

  logic [CW-1:0] chip_q;
  logic [DW-1:0] dly_q;
  logic          pend_q;
  logic          restart;
  logic [CW:0]   shifted;

  assign restart = pend_q && (dly_q == '0) && !sync_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (sync_i) begin
      pend_q <= 1'b1;
      dly_q  <= delay_i;
    end else if (restart) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      dly_q  <= dly_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         chip_q <= '0;
    else if (restart)   chip_q <= '0;
    else if (chip_en_i) chip_q <= (chip_q == LAST) ? '0 : chip_q + 1'b1;
  end

  // Offsetting by the lead-in run puts every sign change on a bit boundary.
  assign shifted  = {1'b0, chip_q} + LEAD;
  assign negate_o = div_en_i & shifted[RUN_BIT];

  // R5
  chip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_q <= LAST);

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en_i && !restart && chip_q == LAST |=> chip_q == '0);

  // R6
  chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i && !restart |=> $stable(chip_q));

  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> pend_q && dly_q == $past(delay_i));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> chip_q == '0 && !pend_q);

  // R8
  pend_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !sync_i && dly_q != '0 |=> pend_q && dly_q == $past(dly_q) - 1'b1);
endmodule

// File: tb/div_sign_seq_tb_top.sv
`timescale 1ns/100ps
module div_sign_seq_tb_top;
  localparam int FRAME = 38400;

  typedef struct {
    bit    exp;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [15:0] delay_i = '0;
  logic        div_en_i = 1'b0;
  logic        chip_en_i = 1'b0;
  logic        negate_o;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;

  int  m_pos = 0;
  int  m_dly = 0;
  bit  m_pend = 0;

  always #2.5 clk = ~clk;

  div_sign_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .delay_i(delay_i),
    .div_en_i(div_en_i), .chip_en_i(chip_en_i), .negate_o(negate_o)
  );

  function automatic bit ref_sign(int pos);
    if (pos < 256) return 1'b0;
    return (((pos - 256) / 512) % 2) == 0;
  endfunction

  function automatic string region(int pos);
    if (pos < 256) return "R2";
    if (pos >= FRAME - 256) return "R4";
    return "R3";
  endfunction

  task automatic check(bit act, bit exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: negate_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: apply inputs for one edge, push the output expected after it
  task automatic step(bit s, int d, bit en, bit ce, string tag);
    item_t it;
    @(negedge clk);
    sync_i = s; delay_i = 16'(d); div_en_i = en; chip_en_i = ce;
    if (s) begin
      m_dly = d; m_pend = 1;
      if (ce) m_pos = (m_pos == FRAME - 1) ? 0 : m_pos + 1;
    end else if (m_pend && m_dly == 0) begin
      m_pos = 0; m_pend = 0;
    end else begin
      if (m_pend) m_dly--;
      if (ce) m_pos = (m_pos == FRAME - 1) ? 0 : m_pos + 1;
    end
    it.exp = en && ref_sign(m_pos);
    it.req = (tag == "") ? region(m_pos) : tag;
    q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(negate_o, it.exp, it.req);
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    div_en_i = 1'b1;
    repeat (4) @(posedge clk);
    #1 check(negate_o, 1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;
    #3 check(negate_o, 1'b0, "R1");

    // R7: delayed sync, then over two frames with chip enable every cycle (R2 R3 R4 R5)
    for (int i = 0; i < 300; i++) step(0, 0, 1, 1, "R1");
    step(1, 5, 1, 1, "R7");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, "R7");
    for (int i = 0; i < 2 * FRAME + 600; i++)
      step(0, 0, 1, 1, (i > FRAME && i < FRAME + 300) ? "R5" : "");

    // R6: chip enable at half rate
    for (int i = 0; i < 3000; i++) step(0, 0, 1, i % 2, "R6");

    // R8: resync while a long delay is pending
    step(1, 200, 1, 1, "R8");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 1, "R8");
    step(1, 3, 1, 1, "R8");
    for (int i = 0; i < 1200; i++) step(0, 0, 1, 1, "R8");

    // R9: diversity off across sign changes
    for (int i = 0; i < 2000; i++) step(0, 0, 0, 1, "R9");

    // R10: zero delay restart
    for (int i = 0; i < 500; i++) step(0, 0, 1, 1, "R10");
    step(1, 0, 1, 1, "R10");
    for (int i = 0; i < 800; i++) step(0, 0, 1, 1, "R10");

    @(posedge clk); #2;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule